// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address when a translation is missing. It takes one request at a time. For each request it reads a directory entry, then a table entry, through a single memory port. It checks the present bit at both levels and writes the accessed and dirty flags back into memory only when a flag actually changes. It ends each walk with one response: either a physical address or a page fault. On a fault, the linear address of the faulting walk is kept in a fault-address register.

The top 10 bits of the linear address select one 4-byte entry in a 1024-entry directory. The directory sits at the page-aligned address held in `dir_base`. The next 10 bits select one 4-byte entry in the 1024-entry table that the directory entry points to. The final address is the upper 20 bits of the table entry followed by the 12-bit page offset. All three entry flags sit at fixed bit positions: present is bit 0, accessed is bit 5 and dirty is bit 6.

Requests and responses use valid/ready handshakes. `req_ready` is high only while no walk is in progress, so a caller holds `req_valid` until it is taken. A response stays on `rsp_valid` with stable fields until the caller raises `rsp_ready`, and that back-pressure stalls the walker. The memory request port is also valid/ready: a request and its fields stay unchanged until `mem_req_ready` is seen. A write is complete at its handshake. A read is answered later by exactly one `mem_rsp_valid` pulse, and the walker always accepts that pulse.

Top module: `pw_walker`

## Requirements
- R1: The first memory access of a walk reads address {dir_base[31:12], req_laddr[31:22], 2'b00}. dir_base is sampled in the cycle the request is accepted. Its low 12 bits, and any change to it after acceptance, have no effect.
- R2: When the directory entry has bit 0 (present) set, the walker reads the table entry at {directory entry[31:12], req_laddr[21:12], 2'b00}.
- R3: A successful walk responds with rsp_fault=0 and rsp_paddr={table entry[31:12], req_laddr[11:0]}.
- R4: If the directory entry has bit 0 clear, the walk ends with a fault response and makes no further memory access. If the table entry has bit 0 clear, the walk ends with a fault response and writes nothing back. A fault response carries rsp_paddr=0.
- R5: fault_addr is 0 after reset. A faulting walk loads it with that walk's linear address by the time of its fault response. No other walk changes it.
- R6: A present directory entry with bit 5 (accessed) clear is written back to its own address with bit 5 set and all other bits unchanged, including bit 6. This write comes before the table read. A directory entry with bit 5 set is not written.
- R7: The table write-back value is the table entry with bit 5 set, and with bit 6 (dirty) also set if req_write was 1. It is issued before the response, and only when it differs from the value read.
- R8: Only one memory access is outstanding at a time. After a read handshake, no request is issued until mem_rsp_valid. While mem_req_valid is high and mem_req_ready is low, mem_req_we, mem_req_addr and mem_req_wdata stay unchanged.
- R9: req_ready is high exactly when no walk is in progress, and req_valid is ignored while a walk is in progress. rsp_valid with its fields stays stable until rsp_ready, and req_ready rises in the cycle after the response handshake.
- R10: During reset, req_ready=1, rsp_valid=0, mem_req_valid=0 and fault_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical base of the page directory, sampled at request acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write (sets the dirty flag) |
| rsp_valid | output | 1 | Walk finished, response valid (done flag) |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Page fault |
| fault_addr | output | 32 | Linear address of the latest faulting walk |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word address in bytes, 4-byte aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per read |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The hardest case to reach from the ports is an input that must be ignored while a walk is in flight. The bench stresses this in two ways. It drives random values on req_valid, req_laddr and dir_base during every busy cycle. It also drives random read data whenever mem_rsp_valid is low. A walker that resamples any of these produces wrong addresses in later accesses. Random stalls on mem_req_ready and rsp_ready, together with a 0 to 2 cycle read latency, hold requests and responses under back-pressure at every stage. The bench then runs a write to a page whose accessed flag is already set but whose dirty flag is clear, which must cause a dirty-only write-back. A second write to the same page must cause no write-back.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [3:0] {
    WS_IDLE,
    WS_RD_PDE,
    WS_WT_PDE,
    WS_UP_PDE,
    WS_RD_PTE,
    WS_WT_PTE,
    WS_UP_PTE,
    WS_DONE,
    WS_FAULT
  } walk_state_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int AW = 32,
  parameter int IDX_W = 10,
  parameter int ELOG = 2,
  localparam int OFF_W = IDX_W + ELOG,
  localparam int FW = AW - OFF_W
) (
  input  logic [FW-1:0] dir_frame,
  input  logic [FW-1:0] tbl_frame,
  input  logic [FW-1:0] page_frame,
  input  logic [AW-1:0] laddr,
  output logic [AW-1:0] pde_addr,
  output logic [AW-1:0] pte_addr,
  output logic [AW-1:0] phys_addr
);
  // directory index: top IDX_W bits; table index: the IDX_W bits above the offset
  assign pde_addr  = {dir_frame, laddr[AW-1 -: IDX_W], {ELOG{1'b0}}};
  assign pte_addr  = {tbl_frame, laddr[OFF_W +: IDX_W], {ELOG{1'b0}}};
  assign phys_addr = {page_frame, laddr[OFF_W-1:0]};
endmodule

// File: rtl/pw_entry_eval.sv
module pw_entry_eval #(
  parameter int EW = 32,
  parameter int P_BIT = 0,
  parameter int A_BIT = 5,
  parameter int D_BIT = 6,
  parameter bit LEAF = 1'b0
) (
  input  logic [EW-1:0] entry,
  input  logic          wr,
  output logic          present,
  output logic          need_wb,
  output logic [EW-1:0] wb_data
);
  logic          mark_d;
  logic [EW-1:0] set_mask;

  // only the leaf level ever gets a dirty mark
  assign mark_d   = LEAF & wr;
  assign set_mask = (EW'(1) << A_BIT) | (EW'(mark_d) << D_BIT);
  assign wb_data  = entry | set_mask;
  assign need_wb  = (wb_data != entry);
  assign present  = entry[P_BIT];
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        rsp_ready,
  input  logic [1:0]  lvl_present,
  input  logic [1:0]  lvl_need_wb,
  output walk_state_e state,
  output logic        accept,
  output logic [1:0]  capture,
  output logic        load_fault
);
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      WS_IDLE:   if (req_valid) nxt = WS_RD_PDE;
      WS_RD_PDE: if (mem_req_ready) nxt = WS_WT_PDE;
      WS_WT_PDE:
        if (mem_rsp_valid) begin
          if (!lvl_present[0])     nxt = WS_FAULT;
          else if (lvl_need_wb[0]) nxt = WS_UP_PDE;
          else                     nxt = WS_RD_PTE;
        end
      WS_UP_PDE: if (mem_req_ready) nxt = WS_RD_PTE;
      WS_RD_PTE: if (mem_req_ready) nxt = WS_WT_PTE;
      WS_WT_PTE:
        if (mem_rsp_valid) begin
          if (!lvl_present[1])     nxt = WS_FAULT;
          else if (lvl_need_wb[1]) nxt = WS_UP_PTE;
          else                     nxt = WS_DONE;
        end
      WS_UP_PTE: if (mem_req_ready) nxt = WS_DONE;
      WS_DONE, WS_FAULT: if (rsp_ready) nxt = WS_IDLE;
      default:   nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= nxt;
  end

  assign accept     = (state == WS_IDLE) && req_valid;
  assign capture[0] = (state == WS_WT_PDE) && mem_rsp_valid;
  assign capture[1] = (state == WS_WT_PTE) && mem_rsp_valid;
  assign load_fault = (nxt == WS_FAULT) && (state != WS_FAULT);
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int ELOG = 2,
  parameter int P_BIT = 0,
  parameter int A_BIT = 5,
  parameter int D_BIT = 6,
  localparam int OFF_W = IDX_W + ELOG,
  localparam int AW = 2 * IDX_W + OFF_W,
  localparam int FW = AW - OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dir_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_laddr,
  input  logic          req_write,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic [AW-1:0] fault_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_rdata
);
  walk_state_e   state;
  logic          accept;
  logic [1:0]    capture;
  logic          load_fault;
  logic [AW-1:0] la_q;
  logic          wr_q;
  logic [FW-1:0] dirf_q;
  logic [AW-1:0] ent_q   [2];
  logic [AW-1:0] ent_in  [2];
  logic [AW-1:0] ent_wb  [2];
  logic [1:0]    lvl_present;
  logic [1:0]    lvl_need_wb;
  logic [AW-1:0] fault_q;
  logic [AW-1:0] pde_addr;
  logic [AW-1:0] pte_addr;
  logic [AW-1:0] phys_addr;
  logic          unused_dir_low;

  assign unused_dir_low = ^dir_base[OFF_W-1:0];

  pw_walk_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_ready    (rsp_ready),
    .lvl_present  (lvl_present),
    .lvl_need_wb  (lvl_need_wb),
    .state        (state),
    .accept       (accept),
    .capture      (capture),
    .load_fault   (load_fault)
  );

  // one evaluator per level; decisions use live read data, write-backs use the held entry
  for (genvar l = 0; l < 2; l++) begin : g_lvl
    assign ent_in[l] = capture[l] ? mem_rsp_rdata : ent_q[l];
    pw_entry_eval #(
      .EW   (AW),
      .P_BIT(P_BIT),
      .A_BIT(A_BIT),
      .D_BIT(D_BIT),
      .LEAF (l == 1)
    ) u_eval (
      .entry  (ent_in[l]),
      .wr     (wr_q),
      .present(lvl_present[l]),
      .need_wb(lvl_need_wb[l]),
      .wb_data(ent_wb[l])
    );
  end

  pw_addr_gen #(
    .AW   (AW),
    .IDX_W(IDX_W),
    .ELOG (ELOG)
  ) u_addr (
    .dir_frame (dirf_q),
    .tbl_frame (ent_q[0][AW-1:OFF_W]),
    .page_frame(ent_q[1][AW-1:OFF_W]),
    .laddr     (la_q),
    .pde_addr  (pde_addr),
    .pte_addr  (pte_addr),
    .phys_addr (phys_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_q    <= '0;
      wr_q    <= 1'b0;
      dirf_q  <= '0;
      fault_q <= '0;
      for (int l = 0; l < 2; l++) ent_q[l] <= '0;
    end else begin
      if (accept) begin
        la_q   <= req_laddr;
        wr_q   <= req_write;
        dirf_q <= dir_base[AW-1:OFF_W];
      end
      for (int l = 0; l < 2; l++)
        if (capture[l]) ent_q[l] <= mem_rsp_rdata;
      if (load_fault) fault_q <= la_q;
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = pde_addr;
    mem_req_wdata = '0;
    case (state)
      WS_RD_PDE: mem_req_valid = 1'b1;
      WS_UP_PDE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = ent_wb[0];
      end
      WS_RD_PTE: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = pte_addr;
      end
      WS_UP_PTE: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = pte_addr;
        mem_req_wdata = ent_wb[1];
      end
      default: ;
    endcase
  end

  assign req_ready  = (state == WS_IDLE);
  assign rsp_valid  = (state == WS_DONE) || (state == WS_FAULT);
  assign rsp_fault  = (state == WS_FAULT);
  assign rsp_paddr  = (state == WS_DONE) ? phys_addr : '0;
  assign fault_addr = fault_q;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int AW = 32,
  parameter int ELOG = 2,
  parameter int A_BIT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault,
  input logic [AW-1:0] fault_addr,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [AW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid
);
  logic rd_open;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_open <= 1'b1;
    else if (mem_rsp_valid) rd_open <= 1'b0;
  end

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid); // R8
  AST_WB_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[A_BIT]); // R6
  AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> rsp_valid && rsp_fault); // R5
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[ELOG-1:0] == '0); // R2
endmodule

bind pw_walker pw_walker_chk #(.AW(AW), .ELOG(ELOG), .A_BIT(A_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .fault_addr   (fault_addr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pw_walker_test.sv
module pw_walker_test;
  localparam int CLK_NS = 10;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [31:0] fault_addr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  pw_walker uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .fault_addr(fault_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct packed {logic we; logic leaf; logic [31:0] addr; logic [31:0] wd;} op_t;
  typedef struct packed {logic [31:0] la; logic wr; logic [31:0] db;} tx_t;

  logic [31:0] mem [logic [31:0]];
  op_t         exp_ops[$];
  tx_t         txq[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          busy = 0;
  bit          exp_fault;
  logic [31:0] exp_paddr;
  logic [31:0] exp_faddr = '0;
  bit          rd_pending = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr;
  bit          mstall = 0;
  bit          rstall = 0;
  logic [31:0] m_addr, m_wd, r_pa;
  logic        m_we, r_f;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic string op_tag(input op_t o);
    if (o.we) return o.leaf ? "R7" : "R6";
    return o.leaf ? "R2" : "R1";
  endfunction

  // expected accesses and response of one walk, from the requirements
  function automatic void plan_walk(input logic [31:0] la, input logic wr, input logic [31:0] db);
    logic [31:0] pa, pde, ta, pte, nw;
    exp_ops.delete();
    pa  = {db[31:12], la[31:22], 2'b00};
    pde = mrd(pa);
    exp_ops.push_back('{we: 1'b0, leaf: 1'b0, addr: pa, wd: 32'h0});
    if (!pde[0]) begin
      exp_fault = 1; exp_paddr = 0; exp_faddr = la;
      return;
    end
    if (!pde[5]) exp_ops.push_back('{we: 1'b1, leaf: 1'b0, addr: pa, wd: pde | 32'h20});
    ta  = {pde[31:12], la[21:12], 2'b00};
    pte = mrd(ta);
    exp_ops.push_back('{we: 1'b0, leaf: 1'b1, addr: ta, wd: 32'h0});
    if (!pte[0]) begin
      exp_fault = 1; exp_paddr = 0; exp_faddr = la;
      return;
    end
    nw = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nw != pte) exp_ops.push_back('{we: 1'b1, leaf: 1'b1, addr: ta, wd: nw});
    exp_fault = 0;
    exp_paddr = {pte[31:12], la[11:0]};
  endfunction

  task automatic step();
    bit  deliver;
    tx_t t;
    op_t o;
    chk(req_ready == !busy, "R9", "req_ready", 32'(req_ready), 32'(!busy));
    if (rd_pending) chk(!mem_req_valid, "R8", "request while read open", 32'(mem_req_valid), 0);
    if (mstall) chk(mem_req_valid && mem_req_addr == m_addr && mem_req_we == m_we && mem_req_wdata == m_wd,
                    "R8", "held memory request", mem_req_addr, m_addr);
    if (rstall) chk(rsp_valid && rsp_paddr == r_pa && rsp_fault == r_f,
                    "R9", "held response", rsp_paddr, r_pa);
    if (!busy) chk(fault_addr == exp_faddr, "R5", "fault_addr while idle", fault_addr, exp_faddr);
    // drive inputs for the coming edge
    deliver       = rd_pending && rd_cnt == 0;
    mem_rsp_valid = deliver;
    mem_rsp_rdata = deliver ? mrd(rd_addr) : $urandom();
    if (rd_pending && !deliver) rd_cnt--;
    if (deliver) rd_pending = 0;
    mem_req_ready = ($urandom_range(0, 3) != 0);
    rsp_ready     = ($urandom_range(0, 2) != 0);
    if (!busy && txq.size() > 0 && $urandom_range(0, 3) != 0) begin
      req_valid = 1'b1; req_laddr = txq[0].la; req_write = txq[0].wr; dir_base = txq[0].db;
    end else begin
      req_valid = busy ? 1'($urandom_range(0, 1)) : 1'b0;
      req_laddr = $urandom(); req_write = 1'($urandom_range(0, 1)); dir_base = $urandom();
    end
    // handshakes at the coming edge
    if (req_valid && req_ready && !busy) begin
      t = txq.pop_front();
      plan_walk(t.la, t.wr, t.db);
      busy = 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (exp_ops.size() == 0) begin
        chk(0, exp_fault ? "R4" : "R7", "unexpected memory access", mem_req_addr, 0);
      end else begin
        o = exp_ops.pop_front();
        chk(mem_req_we == o.we && mem_req_addr == o.addr && (!o.we || mem_req_wdata == o.wd),
            op_tag(o), o.we ? "write-back data" : "read address",
            o.we ? mem_req_wdata : mem_req_addr, o.we ? o.wd : o.addr);
      end
      if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
      else begin
        rd_pending = 1; rd_addr = mem_req_addr; rd_cnt = $urandom_range(0, 2);
      end
    end
    if (rsp_valid && rsp_ready) begin
      if (!busy) chk(0, "R9", "response while idle", rsp_paddr, 0);
      else begin
        chk(rsp_fault == exp_fault, "R4", "fault flag", 32'(rsp_fault), 32'(exp_fault));
        chk(rsp_paddr == exp_paddr, exp_fault ? "R4" : "R3", "physical address", rsp_paddr, exp_paddr);
        chk(fault_addr == exp_faddr, "R5", "fault_addr at response", fault_addr, exp_faddr);
        chk(exp_ops.size() == 0, exp_ops.size() > 0 ? op_tag(exp_ops[0]) : "R7",
            "missing memory access", 32'(exp_ops.size()), 0);
        busy = 0;
      end
    end
    mstall = mem_req_valid && !mem_req_ready;
    m_addr = mem_req_addr; m_we = mem_req_we; m_wd = mem_req_wdata;
    rstall = rsp_valid && !rsp_ready;
    r_pa = rsp_paddr; r_f = rsp_fault;
  endtask

  task automatic add_tx(input logic [31:0] la, input logic wr, input logic [31:0] db);
    txq.push_back('{la: la, wr: wr, db: db});
  endtask

  initial begin
    int cyc = 0;
    // directed page structure: directory at 0x0010_0000
    mem[32'h0010_0004] = 32'h0020_0003;   // idx 1: present, accessed clear
    mem[32'h0020_0014] = 32'h1234_5003;   // page 5: present, A and D clear
    mem[32'h0010_000C] = 32'h0020_1061;   // idx 3: present, A and D set (D must stay)
    mem[32'h0020_0020] = 32'hABCD_E021;   // page 8: A set, D clear
    for (int d = 4; d < 8; d++) begin
      mem[32'h0010_0000 + 32'(d * 4)] = (32'h0030_0000 + 32'(d << 12)) | ($urandom() & 32'h62)
                                        | 32'($urandom_range(0, 3) != 0);
      for (int t = 0; t < 16; t++)
        mem[32'h0030_0000 + 32'(d << 12) + 32'(t * 4)] = ($urandom() & 32'hFFFF_F000)
                                        | ($urandom() & 32'h62) | 32'($urandom_range(0, 3) != 0);
    end
    add_tx(32'h0040_5ABC, 1'b0, 32'h0010_0000); // R6 R7: both accessed write-backs
    add_tx(32'h0040_5ABC, 1'b0, 32'h0010_0FFF); // R6 R7: no write-back, R1 low bits ignored
    add_tx(32'h0040_5ABC, 1'b1, 32'h0010_0000); // R7: dirty only
    add_tx(32'h0040_5ABC, 1'b1, 32'h0010_0000); // R7: nothing to write
    add_tx(32'h0080_5000, 1'b0, 32'h0010_0000); // R4: directory entry absent
    add_tx(32'h00C0_7123, 1'b1, 32'h0010_0ABC); // R4: table entry absent
    add_tx(32'h0040_5FFF, 1'b0, 32'h0010_0000); // R5: success keeps fault_addr
    add_tx(32'h0040_8010, 1'b1, 32'h0010_0000); // R7: A set, D clear, write
    for (int k = 0; k < 80; k++) begin
      int d = $urandom_range(0, 7);
      int t = $urandom_range(0, 15);
      add_tx({d[9:0], t[9:0], 12'($urandom())}, 1'($urandom_range(0, 1)),
             32'h0010_0000 | ($urandom() & 32'hFFF));
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready in reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R10", "mem_req_valid in reset", 32'(mem_req_valid), 0);
    chk(fault_addr == 32'h0, "R10", "fault_addr in reset", fault_addr, 0);
    rst_n = 1'b1;
    while ((txq.size() > 0 || busy) && cyc < LIMIT) begin
      @(negedge clk);
      step();
      cyc++;
    end
    if (cyc >= LIMIT) chk(0, "R9", "watchdog expired", 32'(cyc), LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule